// File: doc/BRIEF.md
# System Interrupt Router with Level Masking

This block is the shared, system-wide half of a multiprocessor interrupt controller. Up to 32 hardware source lines are sampled every clock into a pending register. Each source bit is converted into a processor interrupt level (1 to 15) by a fixed, many-to-one table. The pending bits that the disable register does not mask are merged into one 16-bit level vector. That vector goes to a single programmable target CPU. Every other CPU sees no hard levels.

Software reaches the block through a simple 32-bit register port. It can read the pending bits, the disable bits and the target CPU number. It can set or clear disable bits with write-one semantics, and it can write the target. Only some disable bits can be written. The others keep their reset value forever, so several sources stay masked for good.

Bit 31 of the disable register is a master switch that cuts off every hard level. The block also drives a display vector: the level view of the raw pending bits, taken before any masking, for the target CPU.

Top module: `irq_router`

## Requirements
- R1: Source bits map to levels as follows. Bits 0,7 go to level 2. Bits 1,8 go to 3. Bits 2,9 go to 5. Bits 3,10 go to 7. Bits 4,11,21 go to 9. Bits 5,12,22 go to 11. Bits 6,13,17 go to 13. Bits 14,15 go to 12. Bit 16 goes to 6. Bit 18 goes to 4. Bit 19 goes to 10. Bit 20 goes to 8. Bits 27..30 go to 15. Level L appears as bit L of a 16-bit vector, and bit 0 of that vector is always 0.
- R2: A source line's pending bit equals its input value from the previous clock edge. Source bits 23, 24, 25, 26 and 31 have no level; their pending bits always read 0 and they never produce a level.
- R3: A read (req_i=1, we_i=0) returns data combinationally from the byte address. Address 0x00 returns pending with bit 31 forced to 0. Address 0x04 returns disable AND 0xF05DFF80. Address 0x10 returns the 4-bit target in bits 3:0. Any other address, and any cycle with no read, returns 0.
- R4: A write to 0x0C sets the disable bits where (wdata AND 0xF05DFF80) is 1. A write to 0x08 clears them in the same way. Disable bits outside 0xF05DFF80 never change. Writes to any other address except 0x10 change nothing.
- R5: While disable bit 31 is 1, every CPU's hard-level vector is 0.
- R6: The effective request is pending AND NOT disable. Setting or clearing disable bits never alters the pending register.
- R7: A write to 0x10 stores wdata[3:0] as the target. A stored target at or above NUM_CPUS is kept and read back, but it matches no CPU.
- R8: Only the CPU whose index equals the target receives the level vector of the effective request. All other CPUs receive 0.
- R9: disp_lvl_o is the level vector of the raw pending bits, ignoring the disable register and master disable.
- R10: After reset, pending is 0, the target is 0 and the disable register holds 0x0FA2007F (so address 0x04 reads 0).
- R11: master_dis_o equals disable bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Hardware interrupt source lines, level sensitive |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| hard_lvl_o | output | NUM_CPUS*16 | Hard-level vectors, CPU c in bits [16c+15:16c] |
| disp_lvl_o | output | 16 | Level view of the raw pending bits for the target CPU |
| master_dis_o | output | 1 | Master disable flag |

## Verification
The bench builds the block with NUM_CPUS=4. With that value, target numbers 4 to 15 can be stored but belong to no CPU, so the bench checks that an out-of-range target silences every output slice while its value still reads back. Four CPUs are also enough to show that the level vector moves to CPU 2 and then to CPU 3 while the other slices stay 0. The vector table covers every level group, the permanently masked sources and the sources that have no level.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int SRC_N  = 32;
  localparam int LVL_N  = 16;
  localparam int TGT_W  = 4;
  localparam int ADDR_W = 5;

  localparam logic [SRC_N-1:0] DIS_RESET = 32'h0FA2_007F;
  localparam logic [SRC_N-1:0] DIS_WMASK = ~DIS_RESET;
  localparam int               MDIS_BIT  = 31;

  localparam logic [ADDR_W-1:0] A_PEND = 5'h00;
  localparam logic [ADDR_W-1:0] A_DIS  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CLR  = 5'h08;
  localparam logic [ADDR_W-1:0] A_SET  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_TGT  = 5'h10;

  function automatic logic [3:0] src_level(input int n);
    case (n)
      0, 7:           return 4'd2;
      1, 8:           return 4'd3;
      2, 9:           return 4'd5;
      3, 10:          return 4'd7;
      4, 11, 21:      return 4'd9;
      5, 12, 22:      return 4'd11;
      6, 13, 17:      return 4'd13;
      14, 15:         return 4'd12;
      16:             return 4'd6;
      18:             return 4'd4;
      19:             return 4'd10;
      20:             return 4'd8;
      27, 28, 29, 30: return 4'd15;
      default:        return 4'd0;
    endcase
  endfunction

  // sources feeding a given level
  function automatic logic [SRC_N-1:0] level_sel(input int lvl);
    logic [SRC_N-1:0] m;
    m = '0;
    for (int n = 0; n < SRC_N; n++) m[n] = (int'(src_level(n)) == lvl);
    return m;
  endfunction

  function automatic logic [SRC_N-1:0] live_sources();
    logic [SRC_N-1:0] m;
    m = '0;
    for (int n = 0; n < SRC_N; n++) m[n] = (src_level(n) != 4'd0);
    return m;
  endfunction

  localparam logic [SRC_N-1:0] SRC_LIVE = live_sources();

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_router_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  output logic [SRC_N-1:0] pend_o
);

  logic [SRC_N-1:0] pend_q;

  // level-less sources are never latched
  for (genvar n = 0; n < SRC_N; n++) begin : g_bit
    if (SRC_LIVE[n]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[n] <= 1'b0;
        else         pend_q[n] <= src_i[n];
      end
    end else begin : g_dead
      assign pend_q[n] = 1'b0;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_N-1:0]  wdata_i,
  input  logic [SRC_N-1:0]  pend_i,
  output logic [SRC_N-1:0]  rdata_o,
  output logic [SRC_N-1:0]  dis_o,
  output logic [TGT_W-1:0]  tgt_o
);

  logic [SRC_N-1:0] dis_q;
  logic [TGT_W-1:0] tgt_q;
  logic [SRC_N-1:0] wbits;
  logic             wr, rd;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wbits = wdata_i & DIS_WMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= DIS_RESET;
    end else if (wr) begin
      case (addr_i)
        A_SET:   dis_q <= dis_q | wbits;
        A_CLR:   dis_q <= dis_q & ~wbits;
        default: dis_q <= dis_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tgt_q <= '0;
    else if (wr && addr_i == A_TGT) tgt_q <= wdata_i[TGT_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        A_PEND:  rdata_o = pend_i & ~(SRC_N'(1) << MDIS_BIT);
        A_DIS:   rdata_o = dis_q & DIS_WMASK;
        A_TGT:   rdata_o = SRC_N'(tgt_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign dis_o = dis_q;
  assign tgt_o = tgt_q;

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_router_pkg::*;
(
  input  logic [SRC_N-1:0] bits_i,
  output logic [LVL_N-1:0] lvl_o
);

  assign lvl_o[0] = 1'b0;

  for (genvar l = 1; l < LVL_N; l++) begin : g_lvl
    localparam logic [SRC_N-1:0] SEL = level_sel(l);
    assign lvl_o[l] = |(bits_i & SEL);
  end

endmodule

// File: rtl/irq_cpu_route.sv
module irq_cpu_route
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic [LVL_N-1:0]          lvl_i,
  input  logic                      mdis_i,
  input  logic [TGT_W-1:0]          tgt_i,
  output logic [NUM_CPUS*LVL_N-1:0] hard_o
);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic hit;
    assign hit = (tgt_i == TGT_W'(c)) & ~mdis_i;
    assign hard_o[c*LVL_N +: LVL_N] = hit ? lvl_i : '0;
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [31:0]               src_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [4:0]                addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic [NUM_CPUS*16-1:0]    hard_lvl_o,
  output logic [15:0]               disp_lvl_o,
  output logic                      master_dis_o
);

  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] dis_q;
  logic [TGT_W-1:0] tgt_q;
  logic [SRC_N-1:0] eff;
  logic [LVL_N-1:0] eff_lvl;

  irq_src_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pend_o (pend_q)
  );

  irq_mask_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend_q),
    .rdata_o (rdata_o),
    .dis_o   (dis_q),
    .tgt_o   (tgt_q)
  );

  assign eff = pend_q & ~dis_q;

  irq_level_map u_map_eff (
    .bits_i (eff),
    .lvl_o  (eff_lvl)
  );

  irq_level_map u_map_raw (
    .bits_i (pend_q),
    .lvl_o  (disp_lvl_o)
  );

  irq_cpu_route #(.NUM_CPUS(NUM_CPUS)) u_route (
    .lvl_i  (eff_lvl),
    .mdis_i (dis_q[MDIS_BIT]),
    .tgt_i  (tgt_q),
    .hard_o (hard_lvl_o)
  );

  assign master_dis_o = dis_q[MDIS_BIT];

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [31:0]               src_i,
  input logic                      req_i,
  input logic                      we_i,
  input logic [4:0]                addr_i,
  input logic [31:0]               wdata_i,
  input logic [31:0]               rdata_o,
  input logic [NUM_CPUS*16-1:0]    hard_lvl_o,
  input logic                      master_dis_o,
  input logic [31:0]               pend_q,
  input logic [31:0]               dis_q,
  input logic [3:0]                tgt_q
);

  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  AST_PEND_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> pend_q == ($past(src_i) & SRC_LIVE)); // R2

  AST_PEND_RD_B31: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_PEND) |-> !rdata_o[31]); // R3

  AST_DIS_RD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_DIS) |-> (rdata_o & ~DIS_WMASK) == '0); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_CLR) |=> (dis_q & $past(wdata_i & DIS_WMASK)) == '0); // R4

  AST_FIXED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> (dis_q & ~DIS_WMASK) == ($past(dis_q) & ~DIS_WMASK)); // R4

  AST_MASTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_dis_o |-> hard_lvl_o == '0); // R5

  AST_TGT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_TGT) |=> tgt_q == $past(wdata_i[3:0])); // R7

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    AST_OFF_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgt_q != 4'(c)) |-> hard_lvl_o[c*16 +: 16] == '0); // R8
  end

endmodule

bind irq_router irq_router_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_i        (src_i),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .hard_lvl_o   (hard_lvl_o),
  .master_dis_o (master_dis_o),
  .pend_q       (pend_q),
  .dis_q        (dis_q),
  .tgt_q        (tgt_q)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;

  localparam int NC = 4;
  localparam logic [31:0] LIVE = 32'h787F_FFFF;
  localparam int NV = 12;

  localparam logic [31:0] V_SRC [NV] = '{
    32'h0000_0000, 32'h0000_0080, 32'h0000_0001, 32'h0000_C000,
    32'h0001_0000, 32'h000C_0000, 32'h0050_0000, 32'h1000_0000,
    32'h0800_0000, 32'h8780_0000, 32'h0000_3F00, 32'h0022_0000
  };
  localparam logic [15:0] V_HARD [NV] = '{
    16'h0000, 16'h0004, 16'h0000, 16'h1000,
    16'h0040, 16'h0410, 16'h0900, 16'h8000,
    16'h0000, 16'h0000, 16'h2AA8, 16'h0000
  };
  localparam logic [15:0] V_RAW [NV] = '{
    16'h0000, 16'h0004, 16'h0004, 16'h1000,
    16'h0040, 16'h0410, 16'h0900, 16'h8000,
    16'h8000, 16'h0000, 16'h2AA8, 16'h2200
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       src = '0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [4:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NC*16-1:0]  hard;
  logic [15:0]       disp;
  logic              mdis;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_router #(.NUM_CPUS(NC)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .src_i        (src),
    .req_i        (req),
    .we_i         (we),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .hard_lvl_o   (hard),
    .disp_lvl_o   (disp),
    .master_dis_o (mdis)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic drive_src(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
  endtask

  function automatic logic [63:0] one_cpu(input int c, input logic [15:0] v);
    logic [63:0] r;
    r = '0;
    r[c*16 +: 16] = v;
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(5'h00, d); chk("R10 pend", d, 0);
    rd(5'h04, d); chk("R10 dis", d, 0);
    rd(5'h10, d); chk("R10 tgt", d, 0);
    chk("R10 mdis", mdis, 0);
    chk("R10 hard", hard, 0);

    // R1 R2 R6 R8 R9 vector table, target 0
    for (int i = 0; i < NV; i++) begin
      drive_src(V_SRC[i]);
      chk($sformatf("R1 hard v%0d", i), hard, one_cpu(0, V_HARD[i]));
      chk($sformatf("R9 disp v%0d", i), disp, V_RAW[i]);
      rd(5'h00, d);
      chk($sformatf("R2 pend v%0d", i), d, V_SRC[i] & LIVE);
    end

    // R6 masking keeps pending
    drive_src(32'h0001_0000);
    wr(5'h0C, 32'h0001_0000);
    chk("R6 masked hard", hard, 0);
    rd(5'h00, d); chk("R6 pend kept", d, 32'h0001_0000);
    rd(5'h04, d); chk("R4 set read", d, 32'h0001_0000);
    wr(5'h08, 32'h0001_0000);
    #1 chk("R6 unmasked hard", hard, one_cpu(0, 16'h0040));
    rd(5'h04, d); chk("R4 clr read", d, 0);

    // R4 fixed bits cannot change
    wr(5'h0C, 32'h0FA2_007F);
    rd(5'h04, d); chk("R4 fixed set", d, 0);
    drive_src(32'h0000_0080);
    chk("R4 bit7 still on", hard, one_cpu(0, 16'h0004));
    wr(5'h08, 32'hFFFF_FFFF);
    drive_src(32'h0000_0001);
    chk("R4 bit0 stays off", hard, 0);

    // R5 R11 master disable
    drive_src(32'h1000_0080);
    wr(5'h0C, 32'h8000_0000);
    #1 chk("R11 mdis set", mdis, 1);
    chk("R5 all hard zero", hard, 0);
    chk("R9 disp under mdis", disp, 16'h8004);
    rd(5'h04, d); chk("R5 dis read", d, 32'h8000_0000);
    wr(5'h08, 32'h8000_0000);
    #1 chk("R11 mdis clr", mdis, 0);
    chk("R5 hard back", hard, one_cpu(0, 16'h8004));

    // R7 R8 target
    wr(5'h10, 32'hFFFF_FFF2);
    rd(5'h10, d); chk("R7 tgt low bits", d, 2);
    chk("R8 cpu2 only", hard, one_cpu(2, 16'h8004));
    wr(5'h10, 32'h0000_0003);
    #1 chk("R8 cpu3 only", hard, one_cpu(3, 16'h8004));
    wr(5'h10, 32'h0000_0005);
    rd(5'h10, d); chk("R7 tgt out of range kept", d, 5);
    chk("R7 no cpu hit", hard, 0);
    wr(5'h10, 32'h0000_0000);
    #1 chk("R8 cpu0 back", hard, one_cpu(0, 16'h8004));

    // R3 unmapped, write-only and misaligned offsets
    rd(5'h14, d); chk("R3 rd 14", d, 0);
    rd(5'h08, d); chk("R3 rd 08", d, 0);
    rd(5'h0C, d); chk("R3 rd 0C", d, 0);
    rd(5'h02, d); chk("R3 rd 02", d, 0);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h12, 32'hFFFF_FFFF);
    wr(5'h0E, 32'hFFFF_FFFF);
    rd(5'h04, d); chk("R4 ignored wr dis", d, 0);
    rd(5'h10, d); chk("R4 ignored wr tgt", d, 0);
    chk("R4 ignored wr hard", hard, one_cpu(0, 16'h8004));

    // R10 reset mid-run
    wr(5'h0C, 32'h8001_0000);
    wr(5'h10, 32'h0000_0001);
    @(negedge clk);
    src = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(5'h00, d); chk("R10 pend again", d, 0);
    rd(5'h04, d); chk("R10 dis again", d, 0);
    rd(5'h10, d); chk("R10 tgt again", d, 0);
    chk("R10 mdis again", mdis, 0);
    drive_src(32'h0000_0100);
    chk("R10 routing after reset", hard, one_cpu(0, 16'h0008));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule